// File: doc/BRIEF.md
# Rule-Driven Packet Port Steering

This block chooses the egress ports for each frame that arrives on one of the external ingress ports of a steering segment. Ingress A is paired with host port B and peer port C. Ingress C is paired with host port D and peer port A. Each packet brings a single rule-match bit, qualified by a strobe. From that bit and a global three-way mode, the block produces a destination bitmask. The bitmask can name one port, two ports or none. An empty mask means the frame is dropped.

There are three modes:
- **Bypass:** the match bit picks between the host port and the peer port.
- **Tap:** every frame goes to the peer port, and a matching frame is also copied to the host.
- **Filter:** a matching frame goes to the host and everything else is dropped.

The mode is sampled per lane at packet start, so a frame is always steered by one mode from its first word to its last. Parsing, rule evaluation, buffering and the physical bypass relay are handled elsewhere. The block makes one decision per strobe, back to back, with no stall.

Top module: `pkt_steer`

## Requirements
- R1: Mask bit 0 is port A, bit 1 is port B, bit 2 is port C and bit 3 is port D. Lane 0 (ingress A) uses host B and peer C. Lane 1 (ingress C) uses host D and peer A. A mask never names a port outside its lane's host and peer.
- R2: With mode code 2'b00 (bypass), a matching packet goes to the host port only, and a non-matching packet goes to the peer port only.
- R3: With mode code 2'b01 (tap), every packet goes to the peer port, and a matching packet also goes to the host port.
- R4: With mode code 2'b10 (filter), a matching packet goes to the host port only, and a non-matching packet gets an empty mask.
- R5: Mode code 2'b11 is reserved and steers exactly as filter.
- R6: A lane's valid output rises exactly one clock after its match-valid strobe, and only then. While valid is low, the lane's mask is all zero.
- R7: A drop is reported as valid high with an all-zero mask.
- R8: Each lane takes the mode on its packet-start strobe. A packet-start in the same cycle as match-valid uses the new mode. A change of mode without packet-start has no effect on that lane's decisions.
- R9: Reset clears all valid and mask outputs, and sets each lane's held mode to bypass.
- R10: The lanes hold their modes independently. A packet-start on one lane does not change the mode held by the other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Global steering mode: 00 bypass, 01 tap, 10 filter, 11 reserved |
| sop_i | input | N_LANES | Per-lane packet-start strobe |
| match_vld_i | input | N_LANES | Per-lane strobe qualifying match_i |
| match_i | input | N_LANES | Per-lane rule-match result |
| dst_vld_o | output | N_LANES | Per-lane decision valid |
| dst_mask_o | output | N_LANES*N_PORTS | Per-lane destination mask, lane l at bits [l*N_PORTS +: N_PORTS] |

## Verification
Every decision passes through one register, so the bench drives inputs on a falling edge and compares both lanes at the very next falling edge. That point is one rising edge later, which is where valid and mask must appear. The mode held by each lane also changes at that same rising edge, so the bench's model updates its copy of the mode together with the expected outputs. It therefore scores a mid-packet mode change against the mode taken at the last packet start. In idle cycles the bench checks that valid is low and the mask is zero at that same sampling point.

// File: rtl/pkt_steer_pkg.sv
package pkt_steer_pkg;

   typedef enum logic [1:0] {
      STEER_BYPASS = 2'b00,
      STEER_TAP    = 2'b01,
      STEER_FILTER = 2'b10,
      STEER_RSVD   = 2'b11
   } steer_mode_e;

   // Port index of the host port for a given lane
   function automatic int host_idx(input int lane);
      return 2 * lane + 1;
   endfunction

   // Port index of the peer port: ingress of the next lane around the ring
   function automatic int peer_idx(input int lane, input int n_ports);
      return (2 * lane + 2) % n_ports;
   endfunction

endpackage

// File: rtl/pkt_steer_mode_hold.sv
module pkt_steer_mode_hold
   import pkt_steer_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sop_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [MODE_W-1:0] eff_mode_o
);

   logic [MODE_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= MODE_W'(STEER_BYPASS);
      end else if (sop_i) begin
         held_q <= mode_i;
      end
   end

   // A packet starting now is steered by the mode presented with its start
   always_comb begin
      eff_mode_o = sop_i ? mode_i : held_q;
   end

endmodule

// File: rtl/pkt_steer_decide.sv
module pkt_steer_decide
   import pkt_steer_pkg::*;
#(
   parameter int N_PORTS  = 4,
   parameter int HOST_IDX = 1,
   parameter int PEER_IDX = 2
) (
   input  logic [1:0]         mode_i,
   input  logic               match_i,
   output logic [N_PORTS-1:0] mask_o
);

   localparam logic [N_PORTS-1:0] HOST_BIT = N_PORTS'(1) << HOST_IDX;
   localparam logic [N_PORTS-1:0] PEER_BIT = N_PORTS'(1) << PEER_IDX;

   logic [N_PORTS-1:0] host_sel;

   always_comb begin
      host_sel = match_i ? HOST_BIT : '0;
      unique case (steer_mode_e'(mode_i))
         STEER_BYPASS: mask_o = match_i ? HOST_BIT : PEER_BIT;
         STEER_TAP:    mask_o = PEER_BIT | host_sel;
         STEER_FILTER: mask_o = host_sel;
         default:      mask_o = host_sel;
      endcase
   end

endmodule

// File: rtl/pkt_steer_out_reg.sv
module pkt_steer_out_reg #(
   parameter int N_PORTS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vld_i,
   input  logic [N_PORTS-1:0] mask_i,
   output logic               vld_o,
   output logic [N_PORTS-1:0] mask_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         mask_o <= '0;
      end else begin
         vld_o  <= vld_i;
         mask_o <= vld_i ? mask_i : '0;
      end
   end

endmodule

// File: rtl/pkt_steer.sv
module pkt_steer
   import pkt_steer_pkg::*;
#(
   parameter int N_LANES = 2,
   parameter int N_PORTS = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 mode_i,
   input  logic [N_LANES-1:0]         sop_i,
   input  logic [N_LANES-1:0]         match_vld_i,
   input  logic [N_LANES-1:0]         match_i,
   output logic [N_LANES-1:0]         dst_vld_o,
   output logic [N_LANES*N_PORTS-1:0] dst_mask_o
);

   localparam int MODE_W = 2;

   if (N_LANES < 2) begin : g_cfg_lanes
      $error("pkt_steer: N_LANES must be at least 2");
   end
   if (N_PORTS != 2 * N_LANES) begin : g_cfg_ports
      $error("pkt_steer: N_PORTS must equal 2*N_LANES");
   end

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      logic [MODE_W-1:0]  eff_mode;
      logic [N_PORTS-1:0] next_mask;

      pkt_steer_mode_hold #(.MODE_W(MODE_W)) u_hold (
         .clk        (clk),
         .rst_n      (rst_n),
         .sop_i      (sop_i[l]),
         .mode_i     (mode_i),
         .eff_mode_o (eff_mode)
      );

      pkt_steer_decide #(
         .N_PORTS  (N_PORTS),
         .HOST_IDX (host_idx(l)),
         .PEER_IDX (peer_idx(l, N_PORTS))
      ) u_decide (
         .mode_i  (eff_mode),
         .match_i (match_i[l]),
         .mask_o  (next_mask)
      );

      pkt_steer_out_reg #(.N_PORTS(N_PORTS)) u_out (
         .clk    (clk),
         .rst_n  (rst_n),
         .vld_i  (match_vld_i[l]),
         .mask_i (next_mask),
         .vld_o  (dst_vld_o[l]),
         .mask_o (dst_mask_o[l*N_PORTS +: N_PORTS])
      );
   end

endmodule

// File: rtl/pkt_steer_chk.sv
module pkt_steer_chk
   import pkt_steer_pkg::*;
#(
   parameter int N_LANES = 2,
   parameter int N_PORTS = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [1:0]                 mode_i,
   input logic [N_LANES-1:0]         sop_i,
   input logic [N_LANES-1:0]         match_vld_i,
   input logic [N_LANES-1:0]         match_i,
   input logic [N_LANES-1:0]         dst_vld_o,
   input logic [N_LANES*N_PORTS-1:0] dst_mask_o
);

   for (genvar l = 0; l < N_LANES; l++) begin : g_chk
      localparam logic [N_PORTS-1:0] H = N_PORTS'(1) << host_idx(l);
      localparam logic [N_PORTS-1:0] P = N_PORTS'(1) << peer_idx(l, N_PORTS);
      logic [N_PORTS-1:0] m;
      assign m = dst_mask_o[l*N_PORTS +: N_PORTS];

      p_vld_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
         match_vld_i[l] |=> dst_vld_o[l]);
      p_vld_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !match_vld_i[l] |=> !dst_vld_o[l]);
      p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !dst_vld_o[l] |-> (m == '0));
      p_lane_ports_r1: assert property (@(posedge clk) disable iff (!rst_n)
         dst_vld_o[l] |-> ((m & ~(H | P)) == '0));
      p_bypass_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (sop_i[l] && match_vld_i[l] && mode_i == 2'b00) |=> $countones(m) == 1);
      p_tap_peer_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (sop_i[l] && match_vld_i[l] && mode_i == 2'b01) |=> (m & P) != '0);
      p_filter_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (sop_i[l] && match_vld_i[l] && !match_i[l] && mode_i == 2'b10) |=> m == '0);
      p_rsvd_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (sop_i[l] && match_vld_i[l] && match_i[l] && mode_i == 2'b11) |=> m == H);
   end

endmodule

bind pkt_steer pkt_steer_chk #(.N_LANES(N_LANES), .N_PORTS(N_PORTS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_i      (mode_i),
   .sop_i       (sop_i),
   .match_vld_i (match_vld_i),
   .match_i     (match_i),
   .dst_vld_o   (dst_vld_o),
   .dst_mask_o  (dst_mask_o)
);

// File: tb/pkt_steer_tb_top.sv
module pkt_steer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_i = 2'b00;
   logic [1:0] sop_i = '0;
   logic [1:0] match_vld_i = '0;
   logic [1:0] match_i = '0;
   logic [1:0] dst_vld_o;
   logic [7:0] dst_mask_o;

   int total = 0;
   int bad = 0;

   logic [1:0] held [2];
   logic       exp_vld [2];
   logic [3:0] exp_mask [2];
   string      exp_tag [2];

   always #10 clk = ~clk;

   pkt_steer dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode_i),
      .sop_i       (sop_i),
      .match_vld_i (match_vld_i),
      .match_i     (match_i),
      .dst_vld_o   (dst_vld_o),
      .dst_mask_o  (dst_mask_o)
   );

   // R1: bit0=A bit1=B bit2=C bit3=D; lane0 host B peer C, lane1 host D peer A
   function automatic logic [3:0] model(input int lane, input logic [1:0] m, input logic hit);
      logic [3:0] h = (lane == 0) ? 4'b0010 : 4'b1000;
      logic [3:0] p = (lane == 0) ? 4'b0100 : 4'b0001;
      case (m)
         2'b00:   return hit ? h : p;           // R2
         2'b01:   return p | (hit ? h : 4'b0);  // R3
         default: return hit ? h : 4'b0;        // R4, R5
      endcase
   endfunction

   function automatic string tag_for(input logic [1:0] m, input logic s, input logic [1:0] cur, input logic hit);
      if (!s && cur != m) return "R8";
      case (m)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return hit ? "R4" : "R7";
         default: return "R5";
      endcase
   endfunction

   task automatic check_lanes();
      for (int l = 0; l < 2; l++) begin
         total++;
         if (dst_vld_o[l] !== exp_vld[l] || dst_mask_o[l*4 +: 4] !== exp_mask[l]) begin
            bad++;
            $display("FAIL %s lane %0d: vld=%0b mask=%b expected vld=%0b mask=%b",
                     exp_vld[l] ? exp_tag[l] : "R6", l, dst_vld_o[l], dst_mask_o[l*4 +: 4],
                     exp_vld[l], exp_mask[l]);
         end
      end
   endtask

   // Drive one cycle of stimulus, then check one rising edge later
   task automatic step(input logic [1:0] m, input logic [1:0] s, input logic [1:0] v, input logic [1:0] h);
      mode_i = m; sop_i = s; match_vld_i = v; match_i = h;
      for (int l = 0; l < 2; l++) begin
         logic [1:0] eff = s[l] ? m : held[l];
         exp_vld[l]  = v[l];
         exp_mask[l] = v[l] ? model(l, eff, h[l]) : 4'b0;
         exp_tag[l]  = tag_for(eff, s[l], m, h[l]);
         if (s[l]) held[l] = m;
      end
      @(negedge clk);
      check_lanes();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h0000_5A17));
      held[0] = 2'b00; held[1] = 2'b00;
      match_vld_i = 2'b11; match_i = 2'b11;
      repeat (3) @(negedge clk);
      // R9: reset clears outputs even with strobes held high
      exp_vld[0] = 0; exp_vld[1] = 0; exp_mask[0] = 0; exp_mask[1] = 0;
      exp_tag[0] = "R9"; exp_tag[1] = "R9";
      total++;
      if (dst_vld_o !== 2'b00 || dst_mask_o !== 8'h00) begin
         bad++;
         $display("FAIL R9 reset: vld=%b mask=%h expected vld=00 mask=00", dst_vld_o, dst_mask_o);
      end
      match_vld_i = 0; match_i = 0;
      rst_n = 1'b1;
      @(negedge clk);
      check_lanes(); // R6 idle after reset

      // R9: held mode after reset is bypass, tap on the bus without sop ignored
      step(2'b01, 2'b00, 2'b11, 2'b11); // expect B and D only
      // R8: filter taken at sop, later bypass without sop ignored
      step(2'b10, 2'b01, 2'b01, 2'b00); // lane0 drop (R7)
      step(2'b00, 2'b00, 2'b01, 2'b00); // still filter: drop
      step(2'b00, 2'b01, 2'b01, 2'b00); // bypass now: peer C
      // R5: reserved code acts as filter
      step(2'b11, 2'b11, 2'b11, 2'b11);
      step(2'b11, 2'b00, 2'b11, 2'b00);
      // R10: sop on lane1 only with tap; lane0 keeps reserved/filter
      step(2'b01, 2'b10, 2'b11, 2'b00);
      step(2'b00, 2'b00, 2'b11, 2'b01);
      // R3: tap with match on both lanes
      step(2'b01, 2'b11, 2'b11, 2'b11);
      // R6: no strobe gives invalid, zero mask
      step(2'b10, 2'b00, 2'b00, 2'b11);

      for (int i = 0; i < 3000; i++) begin
         logic [1:0] s, v;
         s[0] = ($urandom % 4) == 0;
         s[1] = ($urandom % 4) == 0;
         v    = 2'($urandom);
         step(2'($urandom), s, v, 2'($urandom));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule